// File: doc/BRIEF.md
# Configurable Pad Output Cell

This block is the output half of one programmable I/O site. A set of static configuration inputs picks where the pad's data comes from. It can be a single registered bit. It can be a pair of registered bits interleaved on the two halves of a clock for double-data-rate transfer. It can be a registered bit in one clock half and a combinational bit in the other. It can be a two-input logic function of the combinational bit and the clock. The chosen value can be inverted before it reaches the pad. A separate three-state path has its own polarity, optional registration and an open-drain override. The pad is modelled as a data value `pad_o` together with a drive enable `pad_oe`.

Three flip-flops are inside the cell: a rising-half data register, a falling-half data register and a three-state register. All of them are clocked on the rising edge of the effective clock, which is `sclk` optionally inverted. Each has its own configured load value, used for both set and reset. A global set/reset loads that value asynchronously and wins over everything else. A local set/reset, which can be disabled, loads it synchronously. A clock enable, which can be bypassed, gates only the two data registers. Every control input has its own inversion bit. Configuration is expected to change only while global set/reset is active. A clock edge must occur inside that window, so that changed load values take effect.

Top module: `oc_pad_out_cell`

## Requirements
- R1: With `cfg_mode`=0 (single rate), `pad_o` shows the rising-half register, which captures `d_rise` on each effective clock edge.
- R2: With `cfg_mode`=1 (double rate), `pad_o` shows the rising-half register while the select clock is 1 and the falling-half register (captured from `d_fall` on the same edge) while it is 0.
- R3: The select clock is `sclk` when `cfg_sel_eclk`=0 and `eclk` when it is 1, XORed with `cfg_clk_inv` in both cases.
- R4: With `cfg_mode`=2, `pad_o` shows the rising-half register while the select clock is 1 and the combinational input `d_comb` while it is 0.
- R5: With `cfg_mode`=3, `pad_o` is f(`d_comb`, select clock), with `cfg_fn` codes 0 AND, 1 NAND, 2 OR, 3 NOR, 4 XOR, 5 XNOR; codes 6 and 7 act as AND.
- R6: `cfg_out_inv`=1 inverts the final data bit in every mode.
- R7: Outside open drain, `pad_oe` equals the three-state source when `cfg_ts_pol`=0, its complement when 1, and is always 1 when 2 or 3. The source is `t_in` directly when `cfg_ts_reg`=0, and the three-state register (loaded from `t_in`) when 1.
- R8: With `cfg_od`=1, `pad_o` is 0 and `pad_oe` is the complement of the final data bit, so the pad never drives 1. The three-state settings have no effect.
- R9: Global set/reset is active when `gsr` XOR `cfg_gsr_inv` is 1. It loads `cfg_hi_set`, `cfg_lo_set` and `cfg_ts_set` into the three registers at once, without waiting for a clock, and overrides local set/reset and clock enable.
- R10: When `cfg_lsr_en`=1 and `lsr` XOR `cfg_lsr_inv` is 1, an edge loads all three registers with their load values, whatever the clock enable says. When `cfg_lsr_en`=0, `lsr` is ignored.
- R11: When `cfg_ce_en`=1, the data registers update only if `ce` XOR `cfg_ce_inv` is 1. The three-state register ignores the clock enable. When `cfg_ce_en`=0 they update on every edge.
- R12: `cfg_clk_inv`=1 makes the registers capture on the falling edge of `sclk` and inverts the select clock.
- R13: In double-rate mode, the half cycle after global set/reset is released shows the falling-half register's load value, before any new capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | System clock; register clock and default select clock |
| eclk | input | 1 | Alternate select clock for the output multiplexer |
| gsr | input | 1 | Global set/reset (polarity per `cfg_gsr_inv`) |
| lsr | input | 1 | Local set/reset (polarity per `cfg_lsr_inv`) |
| ce | input | 1 | Clock enable for the data registers |
| d_rise | input | 1 | Data for the rising-half register |
| d_fall | input | 1 | Data for the falling-half register |
| d_comb | input | 1 | Combinational data bit |
| t_in | input | 1 | Three-state control input |
| cfg_mode | input | 2 | Output source: 0 single, 1 double rate, 2 reg/comb, 3 logic |
| cfg_fn | input | 3 | Logic function code for mode 3 |
| cfg_sel_eclk | input | 1 | 1 = select clock taken from `eclk` |
| cfg_clk_inv | input | 1 | Invert the register clock and the select clock |
| cfg_ce_en | input | 1 | 1 = clock enable honoured |
| cfg_ce_inv | input | 1 | Invert `ce` |
| cfg_lsr_en | input | 1 | 1 = local set/reset honoured |
| cfg_lsr_inv | input | 1 | Invert `lsr` |
| cfg_gsr_inv | input | 1 | Invert `gsr` |
| cfg_hi_set | input | 1 | Load value of the rising-half register |
| cfg_lo_set | input | 1 | Load value of the falling-half register |
| cfg_ts_set | input | 1 | Load value of the three-state register |
| cfg_out_inv | input | 1 | Invert the final data bit |
| cfg_ts_pol | input | 2 | 0 active high, 1 active low, 2/3 always driven |
| cfg_ts_reg | input | 1 | 1 = three-state taken from its register |
| cfg_od | input | 1 | Open-drain mode |
| pad_o | output | 1 | Pad data value |
| pad_oe | output | 1 | Pad drive enable |

## Verification
The bench aims at the moments when the data shown depends on the half of the clock. Every capture is checked in both halves, so a double-rate multiplexer with its halves swapped, or one wired to the wrong select clock, shows the wrong register half the time. The bench releases reset in the low half of a double-rate configuration with unequal load values. A cell that let the first capture leak through, or that loaded the wrong value, would show the rising value too early. Global set/reset is pulsed in the middle of a half cycle with inverted polarity, so a synchronous implementation would lag by up to a cycle. Local set/reset is mixed with random clock enables, and an enable ranked above the local reset would keep stale data. Falling-edge capture and the open-drain override are also exercised. Getting these wrong would show as captures on the wrong edge, or as a pad that drives a 1.

// File: rtl/oc_pkg.sv
package oc_pkg;

    localparam int MODE_W = 2;
    localparam int FN_W   = 3;
    localparam int POL_W  = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_SINGLE  = 2'd0,
        MODE_DOUBLE  = 2'd1,
        MODE_REGCOMB = 2'd2,
        MODE_LOGIC   = 2'd3
    } out_mode_e;

    typedef enum logic [POL_W-1:0] {
        TS_ACT_HIGH = 2'd0,
        TS_ACT_LOW  = 2'd1,
        TS_ON_A     = 2'd2,
        TS_ON_B     = 2'd3
    } ts_pol_e;

    // Two-input gate selected by code; unused codes fall back to AND.
    function automatic logic apply_fn(input logic [FN_W-1:0] code,
                                      input logic a, input logic b);
        logic r;
        case (code)
            3'd1:    r = ~(a & b);
            3'd2:    r = a | b;
            3'd3:    r = ~(a | b);
            3'd4:    r = a ^ b;
            3'd5:    r = ~(a ^ b);
            default: r = a & b;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/oc_sr_flop.sv
module oc_sr_flop (
    input  logic clk,
    input  logic gsr_a,
    input  logic lsr_a,
    input  logic ce_a,
    input  logic load_val,
    input  logic d,
    output logic q
);
    // Asynchronous global load, then synchronous local load, then enable.
    always_ff @(posedge clk or posedge gsr_a) begin
        if (gsr_a)      q <= load_val;
        else if (lsr_a) q <= load_val;
        else if (ce_a)  q <= d;
    end
endmodule

// File: rtl/oc_out_mux.sv
module oc_out_mux
    import oc_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic [FN_W-1:0]   fn,
    input  logic              sel,
    input  logic              r_hi,
    input  logic              r_lo,
    input  logic              d_comb,
    input  logic              out_inv,
    output logic              dout
);
    out_mode_e mode_e;
    logic      raw;

    assign mode_e = out_mode_e'(mode);

    always_comb begin
        unique case (mode_e)
            MODE_SINGLE:  raw = r_hi;
            MODE_DOUBLE:  raw = sel ? r_hi : r_lo;
            MODE_REGCOMB: raw = sel ? r_hi : d_comb;
            MODE_LOGIC:   raw = apply_fn(fn, d_comb, sel);
        endcase
    end

    assign dout = raw ^ out_inv;
endmodule

// File: rtl/oc_ts_ctrl.sv
module oc_ts_ctrl
    import oc_pkg::*;
(
    input  logic             clk,
    input  logic             gsr_a,
    input  logic             lsr_a,
    input  logic             ts_set,
    input  logic             t_in,
    input  logic             ts_reg,
    input  logic [POL_W-1:0] ts_pol,
    input  logic             od,
    input  logic             dout,
    output logic             pad_o,
    output logic             pad_oe
);
    logic    ts_q;
    logic    ts_src;
    logic    oe_norm;
    ts_pol_e pol_e;

    // The three-state register ignores the clock enable.
    oc_sr_flop u_ts_ff (
        .clk      (clk),
        .gsr_a    (gsr_a),
        .lsr_a    (lsr_a),
        .ce_a     (1'b1),
        .load_val (ts_set),
        .d        (t_in),
        .q        (ts_q)
    );

    assign pol_e  = ts_pol_e'(ts_pol);
    assign ts_src = ts_reg ? ts_q : t_in;

    always_comb begin
        unique case (pol_e)
            TS_ACT_HIGH: oe_norm = ts_src;
            TS_ACT_LOW:  oe_norm = ~ts_src;
            TS_ON_A,
            TS_ON_B:     oe_norm = 1'b1;
        endcase
    end

    assign pad_o  = od ? 1'b0  : dout;
    assign pad_oe = od ? ~dout : oe_norm;
endmodule

// File: rtl/oc_pad_out_cell.sv
module oc_pad_out_cell
    import oc_pkg::*;
(
    input  logic              sclk,
    input  logic              eclk,
    input  logic              gsr,
    input  logic              lsr,
    input  logic              ce,
    input  logic              d_rise,
    input  logic              d_fall,
    input  logic              d_comb,
    input  logic              t_in,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic [FN_W-1:0]   cfg_fn,
    input  logic              cfg_sel_eclk,
    input  logic              cfg_clk_inv,
    input  logic              cfg_ce_en,
    input  logic              cfg_ce_inv,
    input  logic              cfg_lsr_en,
    input  logic              cfg_lsr_inv,
    input  logic              cfg_gsr_inv,
    input  logic              cfg_hi_set,
    input  logic              cfg_lo_set,
    input  logic              cfg_ts_set,
    input  logic              cfg_out_inv,
    input  logic [POL_W-1:0]  cfg_ts_pol,
    input  logic              cfg_ts_reg,
    input  logic              cfg_od,
    output logic              pad_o,
    output logic              pad_oe
);
    localparam int N_DATA_FF = 2;

    logic                 clk_int;
    logic                 sel;
    logic                 gsr_a;
    logic                 lsr_a;
    logic                 ce_a;
    logic                 dout;
    logic [N_DATA_FF-1:0] d_vec;
    logic [N_DATA_FF-1:0] set_vec;
    logic [N_DATA_FF-1:0] q_vec;

    // Control polarity and enable decoding.
    assign clk_int = sclk ^ cfg_clk_inv;
    assign sel     = (cfg_sel_eclk ? eclk : sclk) ^ cfg_clk_inv;
    assign gsr_a   = gsr ^ cfg_gsr_inv;
    assign lsr_a   = cfg_lsr_en & (lsr ^ cfg_lsr_inv);
    assign ce_a    = ~cfg_ce_en | (ce ^ cfg_ce_inv);

    // Index 1: rising-half register, index 0: falling-half register.
    assign d_vec   = {d_rise, d_fall};
    assign set_vec = {cfg_hi_set, cfg_lo_set};

    for (genvar i = 0; i < N_DATA_FF; i++) begin : g_data_ff
        oc_sr_flop u_ff (
            .clk      (clk_int),
            .gsr_a    (gsr_a),
            .lsr_a    (lsr_a),
            .ce_a     (ce_a),
            .load_val (set_vec[i]),
            .d        (d_vec[i]),
            .q        (q_vec[i])
        );
    end

    oc_out_mux u_mux (
        .mode    (cfg_mode),
        .fn      (cfg_fn),
        .sel     (sel),
        .r_hi    (q_vec[1]),
        .r_lo    (q_vec[0]),
        .d_comb  (d_comb),
        .out_inv (cfg_out_inv),
        .dout    (dout)
    );

    oc_ts_ctrl u_ts (
        .clk    (clk_int),
        .gsr_a  (gsr_a),
        .lsr_a  (lsr_a),
        .ts_set (cfg_ts_set),
        .t_in   (t_in),
        .ts_reg (cfg_ts_reg),
        .ts_pol (cfg_ts_pol),
        .od     (cfg_od),
        .dout   (dout),
        .pad_o  (pad_o),
        .pad_oe (pad_oe)
    );
endmodule

// File: rtl/oc_pad_out_cell_chk.sv
module oc_pad_out_cell_chk
    import oc_pkg::*;
(
    input logic              sclk,
    input logic              gsr,
    input logic              lsr,
    input logic              ce,
    input logic [MODE_W-1:0] cfg_mode,
    input logic              cfg_clk_inv,
    input logic              cfg_ce_en,
    input logic              cfg_ce_inv,
    input logic              cfg_lsr_en,
    input logic              cfg_lsr_inv,
    input logic              cfg_gsr_inv,
    input logic              cfg_hi_set,
    input logic              cfg_out_inv,
    input logic [POL_W-1:0]  cfg_ts_pol,
    input logic              cfg_od,
    input logic              pad_o,
    input logic              pad_oe
);
    // R8
    od_never_high_chk: assert property (@(posedge sclk) disable iff (gsr ^ cfg_gsr_inv)
        cfg_od |-> !(pad_oe && pad_o));

    // R7
    ts_always_on_chk: assert property (@(posedge sclk) disable iff (gsr ^ cfg_gsr_inv)
        (!cfg_od && cfg_ts_pol[1]) |-> pad_oe);

    // R10
    lsr_load_chk: assert property (@(posedge sclk) disable iff (gsr ^ cfg_gsr_inv)
        (!cfg_clk_inv && cfg_lsr_en && (lsr ^ cfg_lsr_inv) && cfg_mode == 2'd0 && !cfg_od)
        |=> (pad_o == (cfg_hi_set ^ cfg_out_inv)));

    // R11
    ce_hold_chk: assert property (@(posedge sclk) disable iff (gsr ^ cfg_gsr_inv)
        (!cfg_clk_inv && cfg_ce_en && !(ce ^ cfg_ce_inv)
         && !(cfg_lsr_en && (lsr ^ cfg_lsr_inv)) && cfg_mode == 2'd0 && !cfg_od)
        |=> $stable(pad_o));
endmodule

bind oc_pad_out_cell oc_pad_out_cell_chk u_chk (.*);

// File: tb/oc_pad_out_cell_tb.sv
module oc_pad_out_cell_tb;
    logic       sclk = 1'b0;
    logic       eclk_flip = 1'b0;
    logic       eclk;
    logic       gsr = 1'b1, lsr = 1'b0, ce = 1'b1;
    logic       d_rise = 1'b0, d_fall = 1'b0, d_comb = 1'b0, t_in = 1'b0;
    logic [1:0] cfg_mode = 2'd0;
    logic [2:0] cfg_fn = 3'd0;
    logic       cfg_sel_eclk = 0, cfg_clk_inv = 0, cfg_ce_en = 0, cfg_ce_inv = 0;
    logic       cfg_lsr_en = 0, cfg_lsr_inv = 0, cfg_gsr_inv = 0;
    logic       cfg_hi_set = 1, cfg_lo_set = 0, cfg_ts_set = 0, cfg_out_inv = 0;
    logic [1:0] cfg_ts_pol = 2'd0;
    logic       cfg_ts_reg = 1, cfg_od = 0;
    logic       pad_o, pad_oe;

    logic        m_hi, m_lo, m_ts;
    logic [15:0] lf = 16'hACE1;
    int          checks = 0, fails = 0;
    bit          done = 0;

    always #5 sclk = ~sclk;
    assign eclk = sclk ^ eclk_flip;

    oc_pad_out_cell u_dut (.*);

    function automatic logic gate(input logic [2:0] f, input logic a, input logic b);
        if (f == 3'd1) return !(a && b);
        if (f == 3'd2) return a || b;
        if (f == 3'd3) return !(a || b);
        if (f == 3'd4) return a != b;
        if (f == 3'd5) return a == b;
        return a && b;
    endfunction

    task automatic expect_pad(input string req);
        logic s, d, t, eo, eoe;
        s = (cfg_sel_eclk ? eclk : sclk) ^ cfg_clk_inv;
        case (cfg_mode)
            2'd0: d = m_hi;
            2'd1: d = s ? m_hi : m_lo;
            2'd2: d = s ? m_hi : d_comb;
            default: d = gate(cfg_fn, d_comb, s);
        endcase
        d = d ^ cfg_out_inv;
        if (cfg_od) begin
            eo = 1'b0; eoe = !d;
        end else begin
            eo = d;
            t = cfg_ts_reg ? m_ts : t_in;
            eoe = (cfg_ts_pol == 2'd0) ? t : (cfg_ts_pol == 2'd1) ? !t : 1'b1;
        end
        checks++;
        if (pad_o !== eo || pad_oe !== eoe) begin
            fails++;
            $display("FAIL %s t=%0t got o=%b oe=%b expected o=%b oe=%b",
                     req, $time, pad_o, pad_oe, eo, eoe);
        end
    endtask

    task automatic model_load();
        m_hi = cfg_hi_set; m_lo = cfg_lo_set; m_ts = cfg_ts_set;
    endtask

    task automatic next_inputs();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        d_rise = lf[0]; d_fall = lf[3]; d_comb = lf[5]; t_in = lf[7];
    endtask

    // One capture edge, then a check in each half of the clock.
    task automatic cycle(input string req);
        if (cfg_clk_inv) @(negedge sclk); else @(posedge sclk);
        #1;
        if (gsr ^ cfg_gsr_inv) model_load();
        else if (cfg_lsr_en && (lsr ^ cfg_lsr_inv)) model_load();
        else begin
            m_ts = t_in;
            if (!cfg_ce_en || (ce ^ cfg_ce_inv)) begin
                m_hi = d_rise; m_lo = d_fall;
            end
        end
        #1 expect_pad(req);
        #5 expect_pad(req);
    endtask

    task automatic enter_reset();
        cfg_gsr_inv = 1'b0; gsr = 1'b1; #1;
        model_load();
    endtask

    // Clock the new load values in, then release in the low half.
    task automatic leave_reset(input string req);
        @(posedge sclk); @(posedge sclk);
        if (cfg_clk_inv) @(posedge sclk); else @(negedge sclk);
        #2 model_load();
        gsr = cfg_gsr_inv;
        #1 expect_pad(req);
    endtask

    task automatic run(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            next_inputs();
            cycle(req);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R9: reset state, single rate with rising load value 1
        #22 model_load();
        expect_pad("R9 reset state");
        #5 expect_pad("R9 reset state");

        // R1 single rate, R7 registered active-high enable
        leave_reset("R1");
        run(10, "R1 R7");

        // R13 then R2: double rate, unregistered active-low enable
        enter_reset();
        cfg_mode = 2'd1; cfg_hi_set = 0; cfg_lo_set = 1; cfg_ts_reg = 0; cfg_ts_pol = 2'd1;
        leave_reset("R13 first half after release");
        run(10, "R2");

        // R3: select clock from the alternate clock, opposite phase
        enter_reset();
        cfg_sel_eclk = 1; eclk_flip = 1;
        leave_reset("R3");
        run(8, "R3");
        enter_reset();
        cfg_sel_eclk = 0; eclk_flip = 0;

        // R4: registered versus combinational
        cfg_mode = 2'd2;
        leave_reset("R4");
        run(8, "R4");

        // R5: every function code, including a spare code
        for (int f = 0; f < 7; f++) begin
            enter_reset();
            cfg_mode = 2'd3; cfg_fn = 3'(f);
            leave_reset("R5");
            run(4, "R5 logic function");
        end

        // R6 inversion in double rate, R7 always-driven enable
        enter_reset();
        cfg_mode = 2'd1; cfg_out_inv = 1; cfg_ts_pol = 2'd2;
        leave_reset("R6");
        run(8, "R6 R7");

        // R8: open drain, three-state settings ignored
        enter_reset();
        cfg_mode = 2'd0; cfg_out_inv = 0; cfg_od = 1; cfg_ts_pol = 2'd0; cfg_ts_reg = 1;
        leave_reset("R8");
        run(8, "R8 open drain");

        // R11: inverted clock enable; three-state register still loads
        enter_reset();
        cfg_od = 0; cfg_ce_en = 1; cfg_ce_inv = 1;
        leave_reset("R11");
        for (int i = 0; i < 12; i++) begin
            next_inputs(); ce = lf[9];
            cycle("R11 clock enable");
        end

        // R10: local set/reset over clock enable
        enter_reset();
        cfg_ce_inv = 0; cfg_lsr_en = 1; cfg_hi_set = 1; cfg_ts_set = 1;
        leave_reset("R10");
        for (int i = 0; i < 12; i++) begin
            next_inputs(); ce = lf[9]; lsr = lf[11] & lf[12];
            cycle("R10 local set/reset");
        end
        // R10: disabled local set/reset has no effect
        enter_reset();
        cfg_lsr_en = 0; cfg_ce_en = 0; lsr = 1;
        leave_reset("R10");
        run(6, "R10 disabled");
        lsr = 0;

        // R9: inverted global set/reset asserted mid half cycle
        enter_reset();
        gsr = 1'b0; cfg_gsr_inv = 1'b1; cfg_mode = 2'd1; cfg_lo_set = 0;
        leave_reset("R9");
        run(4, "R9");
        gsr = 1'b0; #1 model_load();
        expect_pad("R9 async load");
        cycle("R9 held");
        gsr = 1'b1;
        run(4, "R9 after");

        // R12: falling-edge capture in double rate
        enter_reset();
        cfg_clk_inv = 1;
        leave_reset("R12");
        run(10, "R12 inverted clock");

        finish_run();
    end
endmodule